// File: doc/BRIEF.md
# Multi-Width ALU with Condition Flags

This block is the arithmetic and logic stage of a CPU datapath that handles 8-bit, 16-bit and 32-bit operands. It takes a destination operand, a source operand, an operation code and a size select. It returns a result and a write-back enable in the same cycle. The four condition flags (negative, zero, overflow, carry) are held in a small register that the block owns.

The adder is shared by add, subtract, compare and negate. Subtraction adds the two's-complement negation of the source to the destination. Negation uses the same path with a zero destination. Overflow and carry are found from the operand signs and the unsigned values at the selected width. Compare changes the flags but suppresses write-back. Two pointer-adjust operations add or subtract the source across the full 32 bits and leave the flags alone.

Top module: `mw_alu`

## Requirements
- R1: The flag register `ccr_o` holds N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. It loads on a rising clock edge only when `ccr_we_i` is 1 and the operation sets flags (codes 0 to 6). A synchronous `rst` clears it to 0.
- R2: Code 0 (add) returns dst+src at the selected width. C is set when the unsigned sum does not fit that width.
- R3: Code 1 (subtract) returns dst plus the two's-complement of src at the width. C is set when unsigned src is greater than unsigned dst.
- R4: Code 2 (compare) produces the same result and flags as subtract, with `wb_o` at 0.
- R5: Code 3 (negate) returns 0 minus src at the width. C is set when src at the width is nonzero.
- R6: For codes 0 to 3, V is set when both adder inputs have the same sign bit and the result's sign bit differs from it. The adder inputs are dst (0 for negate) and src (negated for codes 1 to 3).
- R7: N is the result's top bit at the selected width. Z is set when all bits at that width are 0. `result_o` bits above the width are 0.
- R8: Codes 4, 5 and 6 (AND, OR, XOR) set N and Z from the result, clear V and keep C.
- R9: Codes 7 and 8 (pointer add and subtract) return the 32-bit dst+src or dst−src whatever the size select, with `wb_o` at 1. The flags are unchanged even with `ccr_we_i` at 1.
- R10: Codes 9 to 15 give `result_o` 0 and `wb_o` 0, and leave the flags unchanged.
- R11: The size select `size_i` takes these values: 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width select |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| ccr_we_i | input | 1 | Flag register load enable |
| result_o | output | 32 | Result |
| wb_o | output | 1 | Result write-back enable |
| ccr_o | output | 4 | Flag register {N,Z,V,C} |

## Verification
The combinational result and the registered flag update happen together. Two cases test how they interact. A compare with the load enable set must change the flags while `wb_o` stays low. A pointer adjust with the load enable set must assert `wb_o` while the flags hold their previous value. The bench runs every operation with the enable alternating cycle by cycle. It checks `result_o` and `wb_o` just after the inputs settle, then checks `ccr_o` after the next rising edge against a model of the flags kept in the bench. Logic operations are run right after arithmetic ones that leave C set, which shows that C carries over.

// File: rtl/mw_alu_pkg.sv
package mw_alu_pkg;
  parameter int unsigned XLEN = 32;
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned QLEN = XLEN / 4;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_NEG  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_PADD = 4'd7,
    OP_PSUB = 4'd8
  } alu_op_e;

  function automatic word_t size_mask(input logic [1:0] sz);
    word_t m;
    case (sz)
      2'd0:    m = {{(XLEN-QLEN){1'b0}}, {QLEN{1'b1}}};
      2'd1:    m = {{(XLEN-HLEN){1'b0}}, {HLEN{1'b1}}};
      default: m = {XLEN{1'b1}};
    endcase
    return m;
  endfunction

  function automatic logic msb_at(input word_t x, input logic [1:0] sz);
    logic b;
    case (sz)
      2'd0:    b = x[QLEN-1];
      2'd1:    b = x[HLEN-1];
      default: b = x[XLEN-1];
    endcase
    return b;
  endfunction

  function automatic logic sign_ovf(input word_t a, input word_t b, input word_t s,
                                    input logic [1:0] sz);
    return (msb_at(a, sz) == msb_at(b, sz)) && (msb_at(s, sz) != msb_at(a, sz));
  endfunction
endpackage

// File: rtl/mw_alu_adder.sv
module mw_alu_adder
  import mw_alu_pkg::*;
(
  input  alu_op_e    op,
  input  logic [1:0] size,
  input  word_t      dst,
  input  word_t      src,
  output word_t      opa,
  output word_t      opb,
  output word_t      sum
);
  word_t m;

  always_comb begin
    m   = size_mask(size);
    opa = (op == OP_NEG) ? '0 : (dst & m);
    opb = (op == OP_ADD) ? (src & m) : ((~src + 1'b1) & m);
    sum = (opa + opb) & m;
  end
endmodule

// File: rtl/mw_alu_flags.sv
module mw_alu_flags
  import mw_alu_pkg::*;
(
  input  alu_op_e    op,
  input  logic [1:0] size,
  input  logic       arith,
  input  word_t      res,
  input  word_t      opa,
  input  word_t      opb,
  input  word_t      src,
  input  logic       c_old,
  output logic [3:0] nzvc
);
  word_t m;
  logic  n, z, v, c;

  always_comb begin
    m = size_mask(size);
    n = msb_at(res, size);
    z = ((res & m) == '0);
    if (arith) begin
      v = sign_ovf(opa, opb, res, size);
      if (op == OP_ADD) c = (res < opa) || (res < opb);
      else              c = (src & m) > opa;
    end else begin
      v = 1'b0;
      c = c_old;
    end
    nzvc = {n, z, v, c};
  end
endmodule

// File: rtl/mw_alu_ccr.sv
module mw_alu_ccr (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] nzvc,
  output logic [3:0] ccr_q
);
  always_ff @(posedge clk) begin
    if (rst)       ccr_q <= 4'h0;
    else if (load) ccr_q <= nzvc;
  end
endmodule

// File: rtl/mw_alu.sv
module mw_alu
  import mw_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            ccr_we_i,
  output logic [XLEN-1:0] result_o,
  output logic            wb_o,
  output logic [3:0]      ccr_o
);
  alu_op_e op;
  logic    is_arith, is_logic, is_ptr, flag_load;
  word_t   opa, opb, sum, log_res, ptr_res, flag_src;
  logic [3:0] nzvc;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_ptr   = (op == OP_PADD) || (op == OP_PSUB);

  mw_alu_adder u_adder (
    .op(op), .size(size_i), .dst(dst_i), .src(src_i),
    .opa(opa), .opb(opb), .sum(sum)
  );

  always_comb begin
    case (op)
      OP_AND:  log_res = dst_i & src_i;
      OP_OR:   log_res = dst_i | src_i;
      default: log_res = dst_i ^ src_i;
    endcase
    log_res = log_res & size_mask(size_i);
    ptr_res = (op == OP_PADD) ? (dst_i + src_i) : (dst_i - src_i);
    flag_src = is_arith ? sum : log_res;
  end

  mw_alu_flags u_flags (
    .op(op), .size(size_i), .arith(is_arith), .res(flag_src),
    .opa(opa), .opb(opb), .src(src_i), .c_old(ccr_o[0]), .nzvc(nzvc)
  );

  assign flag_load = ccr_we_i && (is_arith || is_logic);

  mw_alu_ccr u_ccr (
    .clk(clk), .rst(rst), .load(flag_load), .nzvc(nzvc), .ccr_q(ccr_o)
  );

  always_comb begin
    if (is_arith)      result_o = sum;
    else if (is_logic) result_o = log_res;
    else if (is_ptr)   result_o = ptr_res;
    else               result_o = '0;
    wb_o = (is_arith && op != OP_CMP) || is_logic || is_ptr;
  end

  // R1: synchronous reset clears the flags
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (ccr_o == 4'h0));
  // R1: flags hold without load enable
  a_r1_hold_no_we: assert property (@(posedge clk) disable iff (rst)
    !ccr_we_i |=> $stable(ccr_o));
  // R4: compare never writes back
  a_r4_cmp_no_wb: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2) |-> !wb_o);
  // R9: pointer adjust leaves the flags alone
  a_r9_ptr_keeps_ccr: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7 || op_i == 4'd8) |=> $stable(ccr_o));
  // R8: logic ops clear V and keep C
  a_r8_logic_vc: assert property (@(posedge clk) disable iff (rst)
    (ccr_we_i && op_i >= 4'd4 && op_i <= 4'd6) |=>
      (ccr_o[1] == 1'b0) && (ccr_o[0] == $past(ccr_o[0])));
  // R7: Z follows a zero result
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (ccr_we_i && op_i <= 4'd6) |=> (ccr_o[2] == ($past(result_o) == '0)));
  // R10: unlisted codes neither write back nor touch flags
  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd9) |-> (!wb_o && result_o == '0));
endmodule

// File: tb/mw_alu_bench.sv
module mw_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op;
  logic [1:0]  sz;
  logic [31:0] dst, src;
  logic        we;
  logic [31:0] result;
  logic        wb;
  logic [3:0]  ccr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [3:0] m_ccr = 4'h0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_alu u_mw_alu (
    .clk(clk), .rst(rst), .op_i(op), .size_i(sz), .dst_i(dst), .src_i(src),
    .ccr_we_i(we), .result_o(result), .wb_o(wb), .ccr_o(ccr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (op=%0d sz=%0d d=%h s=%h)",
               req, act, exp, op, sz, dst, src);
    end
  endtask

  function automatic string req_of(input int o);
    case (o)
      0: return "R2 add";
      1: return "R3 sub";
      2: return "R4 cmp";
      3: return "R5 neg";
      4, 5, 6: return "R8 logic";
      7, 8: return "R9 ptr";
      default: return "R10 undef";
    endcase
  endfunction

  task automatic run(input int o, input int s, input logic [31:0] d,
                     input logic [31:0] v, input logic w);
    longint unsigned mk, dd, ss, bn, a, b, r;
    int  sb;
    bit  fn, fz, fv, fc, setf, ewb;
    logic [31:0] er;
    @(negedge clk);
    op = 4'(o); sz = 2'(s); dst = d; src = v; we = w;
    mk = (s == 0) ? 64'hFF : (s == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
    sb = (s == 0) ? 7 : (s == 1) ? 15 : 31;
    dd = {32'h0, d} & mk; ss = {32'h0, v} & mk;
    bn = ((~ss) + 64'd1) & mk;
    setf = 0; ewb = 1; fv = 0; fc = m_ccr[0]; r = 0;
    case (o)
      0: begin a = dd; b = ss; r = (a + b) & mk; fc = (a + b) > mk; setf = 1; end
      1, 2: begin a = dd; b = bn; r = (a + b) & mk; fc = ss > dd; setf = 1; end
      3: begin a = 0; b = bn; r = bn; fc = (ss != 0); setf = 1; end
      4: begin r = dd & ss; setf = 1; end
      5: begin r = dd | ss; setf = 1; end
      6: begin r = dd ^ ss; setf = 1; end
      7: r = {32'h0, d + v};
      8: r = {32'h0, d - v};
      default: begin r = 0; ewb = 0; end
    endcase
    if (o <= 3) fv = (a[sb] == b[sb]) && (r[sb] != a[sb]);
    if (o == 2) ewb = 0;
    fn = r[sb];
    fz = ((r & mk) == 0);
    er = r[31:0];
    #1;
    chk({req_of(o), " R7 R11 result"}, result, er);
    chk({req_of(o), " wb"}, {31'h0, wb}, {31'h0, ewb});
    if (setf && w) m_ccr = {fn, fz, fv, fc};
    @(posedge clk); #1;
    chk({req_of(o), " R1 R6 flags"}, {28'h0, ccr}, {28'h0, m_ccr});
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; op = 0; sz = 0; dst = 0; src = 0; we = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset value", {28'h0, ccr}, 32'h0);
    @(negedge clk) rst = 0;

    // byte sweep, every op, enable alternating
    for (int o = 0; o <= 6; o++)
      for (int i = 0; i < 18; i++)
        for (int j = 0; j < 18; j++)
          run(o, 0, 32'(i * 15) | 32'h5A00, 32'(j * 15) | 32'hA500, ((i + j) % 3) != 0);

    // boundary corners at each width
    run(0, 0, 32'h7F, 32'h01, 1);          // R6 overflow byte
    run(4, 0, 32'hFF, 32'h0F, 1);          // R8 C carries from previous (0)
    run(0, 0, 32'hFF, 32'h01, 1);          // R2 carry, zero
    run(5, 0, 32'h80, 32'h00, 1);          // R8 C kept at 1, V cleared
    run(3, 0, 32'h0, 32'h80, 1);           // R5 negate of min
    run(3, 1, 32'h1234, 32'h0000, 1);      // R5 negate of zero
    run(1, 1, 32'h8000, 32'h0001, 1);      // R3 word overflow
    run(0, 2, 32'hFFFF_FFFF, 32'h1, 1);    // R2 long carry
    run(2, 2, 32'h1, 32'h2, 1);            // R4 borrow, no wb
    run(7, 0, 32'hFFFF_FFFF, 32'h4, 1);    // R9 full width despite byte size
    run(8, 1, 32'h0000_0001, 32'h2, 1);    // R9 wrap, flags held
    run(12, 2, 32'h1234, 32'h5678, 1);     // R10
    run(6, 3, 32'hFFFF_0000, 32'h0000_FFFF, 1); // R11 size 3 is 32 bits

    // word and long sweeps over all codes
    for (int k = 0; k < 1200; k++) begin
      logic [31:0] a, b;
      lfsr = step(lfsr); a = lfsr;
      lfsr = step(lfsr); b = lfsr;
      if (k % 7 == 0) b = a;
      run(k % 16, 1 + (k % 3), a, b, (k % 4) != 3);
    end

    // R1 reset clears a nonzero register
    run(1, 0, 32'h0, 32'h1, 1);
    @(negedge clk) rst = 1;
    @(posedge clk); #1;
    m_ccr = 4'h0;
    chk("R1 reset clears", {28'h0, ccr}, 32'h0);
    @(negedge clk) rst = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule